// File: doc/BRIEF.md
# Predicate Even/Odd Unzip Unit

This block rearranges two predicate words into one. A predicate carries one bit for each data byte of a vector, so an element of size E bits is E/8 predicate bits wide. The unit takes either the even-numbered or the odd-numbered elements of the first operand and packs them into the lower half of the destination. It then packs the same-parity elements of the second operand into the upper half. The element size and the parity both come from a 32-bit instruction word.

A small decoder checks the fixed bits of that word. It extracts the element-size code, the parity bit and the three register indices, and it flags any word that does not match. The permutation itself is a fixed wiring network selected by the size code. By default the result is captured in an output register on a strobe that carries a matching word, and a parameter can bypass that register. The vector length VL is a parameter: a multiple of 128 up to 2048, which gives a predicate width of VL/8.

Top module: `pred_unzip`

## Requirements
- R1: `dec_hit` is 1 exactly when instr[31:24]=8'b00000101, instr[21:20]=2'b10, instr[15:11]=5'b01001, instr[9]=0 and instr[4]=0.
- R2: While `dec_hit` is 0, `dec_size`, `dec_part`, `src_n`, `src_m` and `dst` are all zero.
- R3: On a matching word, `dec_size`=instr[23:22], `src_m`=instr[19:16], `dec_part`=instr[10], `src_n`=instr[8:5] and `dst`=instr[3:0]. `res_dst` captures `dst` with the result.
- R4: With size code 00 (byte, 1 predicate bit per element), result bit p for p<PW/2 is A bit 2p+part, and result bit PW/2+p is B bit 2p+part.
- R5: With size code 01 (halfword, 2 bits per element), the elements are unzipped in the same way, and the bits inside each element keep their order.
- R6: With size code 10 (word, 4 bits per element), the elements are unzipped in the same way.
- R7: With size code 11 (doubleword, 8 bits per element), the elements are unzipped in the same way.
- R8: Part 0 selects the even elements and part 1 the odd ones. The lower half always comes from A and the upper half from B, and every result bit is written.
- R9: With the output register enabled, `result`, `res_dst` and a 1 on `res_valid` appear one clock after an `in_valid` cycle on which `dec_hit` is 1.
- R10: A cycle without `in_valid`, or with `in_valid` and a non-matching word, leaves `result` and `res_dst` unchanged and gives `res_valid`=0 on the next cycle.
- R11: Synchronous reset clears `result`, `res_dst` and `res_valid` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| instr | input | 32 | Instruction word |
| op_a | input | VL/8 | First predicate operand |
| op_b | input | VL/8 | Second predicate operand |
| dec_hit | output | 1 | Instruction word matches |
| dec_size | output | 2 | Element-size code |
| dec_part | output | 1 | Parity select (0 even, 1 odd) |
| src_n | output | 4 | First source index |
| src_m | output | 4 | Second source index |
| dst | output | 4 | Destination index |
| res_valid | output | 1 | Result valid |
| res_dst | output | 4 | Destination index of held result |
| result | output | VL/8 | Unzipped predicate |

## Verification
A wrong tap in the permutation network corrupts particular bits of `result` for only one size code and one parity. The bench therefore drives every size and parity, using asymmetric operands so that any misplaced bit differs from the expected value on the cycle after the strobe. A wrong load enable on the output register shows up as a changed `result` or a raised `res_valid` on the cycle after a miss or an idle cycle. A decoder fault shows at once on the combinational field outputs.

// File: rtl/pred_unzip_pkg.sv
package pred_unzip_pkg;
  localparam int unsigned NSIZE = 4;
  localparam logic [7:0] MATCH_TOP = 8'b0000_0101;
  localparam logic [1:0] MATCH_MID = 2'b10;
  localparam logic [4:0] MATCH_OPC = 5'b01001;

  typedef struct packed {
    logic       hit;
    logic [1:0] size;
    logic       part;
    logic [3:0] pn;
    logic [3:0] pm;
    logic [3:0] pd;
  } dec_t;
endpackage

// File: rtl/pu_decode.sv
module pu_decode
  import pred_unzip_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic match;

  always_comb begin
    match = (instr[31:24] == MATCH_TOP) && (instr[21:20] == MATCH_MID) &&
            (instr[15:11] == MATCH_OPC) && !instr[9] && !instr[4];
    dec = '0;
    if (match) begin
      dec.hit  = 1'b1;
      dec.size = instr[23:22];
      dec.part = instr[10];
      dec.pm   = instr[19:16];
      dec.pn   = instr[8:5];
      dec.pd   = instr[3:0];
    end
  end
endmodule

// File: rtl/pu_permute.sv
module pu_permute
  import pred_unzip_pkg::*;
#(
  parameter int unsigned PW = 32
) (
  input  logic [1:0]    size,
  input  logic          part,
  input  logic [PW-1:0] a,
  input  logic [PW-1:0] b,
  output logic [PW-1:0] y
);
  localparam int unsigned HALF = PW / 2;

  logic [PW-1:0] cand [NSIZE];

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    localparam int unsigned EB = 1 << s;
    for (genvar i = 0; i < PW; i++) begin : g_bit
      localparam int unsigned ELEM = i / EB;
      localparam int unsigned OFF  = i % EB;
      localparam int unsigned PAIRS = PW / (2 * EB);
      if (i < HALF) begin : g_lo
        localparam int unsigned EV = (2 * ELEM) * EB + OFF;
        assign cand[s][i] = part ? a[EV + EB] : a[EV];
      end else begin : g_hi
        localparam int unsigned EV = (2 * (ELEM - PAIRS)) * EB + OFF;
        assign cand[s][i] = part ? b[EV + EB] : b[EV];
      end
    end
  end

  assign y = cand[size];
endmodule

// File: rtl/pred_unzip.sv
module pred_unzip
  import pred_unzip_pkg::*;
#(
  parameter int unsigned VL      = 256,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned PW     = VL / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [PW-1:0] op_a,
  input  logic [PW-1:0] op_b,
  output logic          dec_hit,
  output logic [1:0]    dec_size,
  output logic          dec_part,
  output logic [3:0]    src_n,
  output logic [3:0]    src_m,
  output logic [3:0]    dst,
  output logic          res_valid,
  output logic [3:0]    res_dst,
  output logic [PW-1:0] result
);
  dec_t          dec;
  logic [PW-1:0] perm;
  logic          load;

  pu_decode u_dec (.instr(instr), .dec(dec));

  pu_permute #(.PW(PW)) u_perm (
    .size(dec.size), .part(dec.part), .a(op_a), .b(op_b), .y(perm)
  );

  assign dec_hit  = dec.hit;
  assign dec_size = dec.size;
  assign dec_part = dec.part;
  assign src_n    = dec.pn;
  assign src_m    = dec.pm;
  assign dst      = dec.pd;
  assign load     = in_valid && dec.hit;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        result    <= '0;
        res_dst   <= '0;
        res_valid <= 1'b0;
      end else begin
        res_valid <= load;
        if (load) begin
          result  <= perm;
          res_dst <= dec.pd;
        end
      end
    end
  end else begin : g_comb
    assign result    = perm;
    assign res_dst   = dec.pd;
    assign res_valid = load;
  end
endmodule

// File: rtl/pu_checker.sv
module pu_checker #(
  parameter int unsigned PW      = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [31:0]   instr,
  input logic          dec_hit,
  input logic [1:0]    dec_size,
  input logic          dec_part,
  input logic [3:0]    src_n,
  input logic [3:0]    src_m,
  input logic [3:0]    dst,
  input logic          res_valid,
  input logic [3:0]    res_dst,
  input logic [PW-1:0] result
);
  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !dec_hit |-> (dec_size == 2'b0 && !dec_part && src_n == 4'd0 &&
                  src_m == 4'd0 && dst == 4'd0));

  assert_field_R3: assert property (@(posedge clk) disable iff (rst)
    dec_hit |-> (dst == instr[3:0] && src_m == instr[19:16]));

  if (REG_OUT) begin : g_seq
    assert_match_R1: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> ($past(instr[31:24]) == 8'b0000_0101));

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && dec_hit) |=> res_valid);

    assert_dst_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && dec_hit) |=> (res_dst == $past(instr[3:0])));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && dec_hit) |=> (!res_valid && $stable(result) && $stable(res_dst)));

    assert_reset_R11: assert property (@(posedge clk)
      rst |=> (!res_valid && result == '0 && res_dst == 4'd0));
  end
endmodule

bind pred_unzip pu_checker #(.PW(PW), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
  .dec_hit(dec_hit), .dec_size(dec_size), .dec_part(dec_part),
  .src_n(src_n), .src_m(src_m), .dst(dst),
  .res_valid(res_valid), .res_dst(res_dst), .result(result)
);

// File: tb/sim_pred_unzip.sv
`timescale 1ns/1ps
module sim_pred_unzip;
  localparam int unsigned VL = 256;
  localparam int unsigned PW = VL / 8;
  localparam int NVEC = 8;

  localparam logic [1:0]  T_SIZE [NVEC] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd2, 2'd3};
  localparam logic        T_PART [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [31:0] T_A [NVEC] = '{32'hAAAAAAAA, 32'hAAAAAAAA, 32'h33333333, 32'h33333333,
                                         32'h0F0F0F0F, 32'h00FF00FF, 32'h12345678, 32'h12345678};
  localparam logic [31:0] T_B [NVEC] = '{32'h00000000, 32'h55555555, 32'hCCCCCCCC, 32'hCCCCCCCC,
                                         32'hF0F0F0F0, 32'hFF00FF00, 32'h9ABCDEF0, 32'h9ABCDEF0};
  localparam logic [31:0] T_EXP [NVEC] = '{32'h00000000, 32'h0000FFFF, 32'h0000FFFF, 32'hFFFF0000,
                                           32'h0000FFFF, 32'hFFFF0000, 32'h9BDF1357, 32'hBCF03478};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [31:0]   instr = '0;
  logic [PW-1:0] op_a = '0;
  logic [PW-1:0] op_b = '0;
  logic          dec_hit, dec_part, res_valid;
  logic [1:0]    dec_size;
  logic [3:0]    src_n, src_m, dst, res_dst;
  logic [PW-1:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pred_unzip #(.VL(VL), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .op_a(op_a), .op_b(op_b), .dec_hit(dec_hit), .dec_size(dec_size),
    .dec_part(dec_part), .src_n(src_n), .src_m(src_m), .dst(dst),
    .res_valid(res_valid), .res_dst(res_dst), .result(result)
  );

  function automatic logic [31:0] mk(input logic [1:0] sz, input logic pt,
                                     input logic [3:0] pn, input logic [3:0] pm,
                                     input logic [3:0] pd);
    return {8'b0000_0101, sz, 2'b10, pm, 5'b01001, pt, 1'b0, pn, 1'b0, pd};
  endfunction

  function automatic logic [PW-1:0] ref_uzp(input logic [1:0] sz, input logic pt,
                                            input logic [PW-1:0] a, input logic [PW-1:0] b);
    logic [PW-1:0] r;
    int eb, pairs, e, off;
    eb = 1 << sz;
    pairs = PW / (2 * eb);
    for (int i = 0; i < PW; i++) begin
      e = i / eb;
      off = i % eb;
      if (e < pairs) r[i] = a[(2 * e + pt) * eb + off];
      else           r[i] = b[(2 * (e - pairs) + pt) * eb + off];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [31:0] w,
                       input logic [PW-1:0] a, input logic [PW-1:0] b);
    @(negedge clk);
    in_valid = v; instr = w; op_a = a; op_b = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [PW-1:0] ra, rb, held;
    logic [3:0] hd;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset result", 64'(result), 64'd0);
    check("R11 reset valid/dst", {59'd0, res_valid, res_dst}, 64'd0);
    @(negedge clk); rst = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      issue(1'b1, mk(T_SIZE[k], T_PART[k], 4'd1, 4'd2, 4'(k + 3)), T_A[k], T_B[k]);
      check($sformatf("R4-7 R8 vec%0d", k), 64'(result), 64'(T_EXP[k]));
      check("R9 valid and dst", {59'd0, res_valid, res_dst}, {59'd0, 1'b1, 4'(k + 3)});
    end

    for (int k = 0; k < 64; k++) begin
      logic [1:0] sz;
      logic pt;
      sz = 2'(k % 4); pt = 1'((k / 4) % 2);
      ra = $urandom; rb = $urandom;
      issue(1'b1, mk(sz, pt, 4'(k), 4'(k + 1), 4'(k + 2)), ra, rb);
      case (sz)
        2'd0: check("R4 random byte", 64'(result), 64'(ref_uzp(sz, pt, ra, rb)));
        2'd1: check("R5 random half", 64'(result), 64'(ref_uzp(sz, pt, ra, rb)));
        2'd2: check("R6 random word", 64'(result), 64'(ref_uzp(sz, pt, ra, rb)));
        default: check("R7 random dword", 64'(result), 64'(ref_uzp(sz, pt, ra, rb)));
      endcase
    end

    @(negedge clk);
    instr = mk(2'b10, 1'b1, 4'd7, 4'd9, 4'd12);
    #1;
    check("R1 hit", {63'd0, dec_hit}, 64'd1);
    check("R3 fields", {48'd0, dec_size, dec_part, src_n, src_m, dst, 1'b0},
          {48'd0, 2'b10, 1'b1, 4'd7, 4'd9, 4'd12, 1'b0});
    instr = mk(2'b10, 1'b1, 4'd7, 4'd9, 4'd12) | 32'h0000_0200;
    #1;
    check("R1 bit9 set", {63'd0, dec_hit}, 64'd0);
    check("R2 zero fields", {49'd0, dec_size, dec_part, src_n, src_m, dst},
          64'd0);
    instr = mk(2'b01, 1'b0, 4'd3, 4'd4, 4'd5) ^ 32'h0010_0000;
    #1;
    check("R1 bits21:20", {63'd0, dec_hit}, 64'd0);

    held = result; hd = res_dst;
    issue(1'b1, mk(2'b00, 1'b0, 4'd1, 4'd1, 4'd9) ^ 32'h0000_0800, '1, '1);
    check("R10 miss holds", 64'(result), 64'(held));
    check("R10 miss valid/dst", {59'd0, res_valid, res_dst}, {59'd0, 1'b0, hd});
    issue(1'b0, mk(2'b00, 1'b0, 4'd1, 4'd1, 4'd9), '1, '0);
    check("R10 idle holds", 64'(result), 64'(held));
    check("R10 idle valid", {63'd0, res_valid}, 64'd0);

    issue(1'b1, mk(2'b00, 1'b1, 4'd1, 4'd1, 4'd6), 32'hFFFFFFFF, 32'hFFFFFFFF);
    check("R8 all bits written", 64'(result), 64'hFFFFFFFF);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R11 reset after use", {27'd0, res_valid, res_dst, result}, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule